// File: doc/BRIEF.md
# Configurable Interleaved Bidirectional Shift Register

This block is the serial-to-parallel loading stage for a column driver. It has 96 storage stages that are split into parallel serial chains, so column data can be loaded over several narrow serial links at once. A run-time mode input selects the split. When it is high, the stages form three chains of 32. When it is low, they form six chains of 16. The chains interleave across the stage numbers: chain k owns every C-th stage starting at stage k, where C is the chain count.

All chains shift together on the rising clock edge. A direction input sets which end of each chain is fed. Each chain has an A-side port at its low end and a B-side port at its high end. The side that receives data acts as the input, and the opposite side presents the chain's far stage as an output for cascading. Each port is modelled as separate data-in, data-out and output-enable signals. An asynchronous active-low clear empties every stage. The whole 96-bit stage vector is always visible, so a downstream latch can capture it.

Top module: `interleaved_shreg`

## Requirements
- R1: While `clr_n` is low, every stage reads 0 at once, with no clock edge needed, and clock edges have no effect.
- R2: Three-chain mode (`mode_wide`=1) with `shift_right`=1: on each rising edge, stage index j (0-based, bit j of `stages`) takes `a_din[j]` for j<3 and takes the old stage j-3 otherwise.
- R3: Six-chain mode (`mode_wide`=0) with `shift_right`=1: stage j takes `a_din[j]` for j<6 and takes the old stage j-6 otherwise.
- R4: Three-chain mode with `shift_right`=0: stage 93+k takes `b_din[k]` for k<3, and every other stage j takes the old stage j+3.
- R5: Six-chain mode with `shift_right`=0: stage 90+k takes `b_din[k]` for k<6, and every other stage j takes the old stage j+6.
- R6: A port is active when its index is below the chain count (3 or 6). During a right shift, `b_oe` is high exactly on the active ports and `a_oe` is all zero. During a left shift, the roles swap. Ports 3 to 5 never drive in three-chain mode.
- R7: `a_dout[k]` equals stage k and `b_dout[k]` equals stage 96-C+k whenever that port's enable is high. Every data-out bit whose enable is low reads 0.
- R8: Port inputs have no effect on the stages in two cases: ports 3 to 5 in three-chain mode, and the data-in group on the side that is currently outputting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of all stages, active low |
| shift_right | input | 1 | 1: A side feeds, B side outputs; 0: the reverse |
| mode_wide | input | 1 | 1: three 32-stage chains; 0: six 16-stage chains |
| a_din | input | 6 | A-side serial data in, one bit per chain |
| a_dout | output | 6 | A-side serial data out |
| a_oe | output | 6 | A-side output enables |
| b_din | input | 6 | B-side serial data in, one bit per chain |
| b_dout | output | 6 | B-side serial data out |
| b_oe | output | 6 | B-side output enables |
| stages | output | 96 | Parallel view of all stages, bit j is stage j |

## Verification
The shift properties compare each edge with the edge before it. They therefore assume that `clr_n` was high at both edges, and that no clear pulse starts and ends between two edges. The stimulus only asserts the clear across at least one rising edge, and it releases the clear on a falling edge. Direction, mode and data inputs change only on falling edges, so every edge samples settled values. The mode is also switched with data already held, to show that the stages are reinterpreted and not lost.

// File: rtl/shreg_pkg.sv
// Package: shared constants and helpers for the interleaved shift register.
// Assumes the stage count divides evenly by both chain counts.
package shreg_pkg;

    localparam int unsigned SHR_STAGES_DEF = 96;
    localparam int unsigned SHR_WIDE_DEF   = 3;
    localparam int unsigned SHR_NARROW_DEF = 6;

    // Direction encoding carried on shift_right.
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shr_dir_e;

    // Number of chains in use for a given mode select.
    function automatic int unsigned chains_in_use(input logic wide,
                                                  input int unsigned n_wide,
                                                  input int unsigned n_narrow);
        return wide ? n_wide : n_narrow;
    endfunction

endpackage

// File: rtl/shreg_next_state.sv
// Module: computes the next value of every stage for both chain layouts
// and both directions, then selects by mode and direction.
// Assumes STAGES is a multiple of WIDE and NARROW, and WIDE < NARROW.
module shreg_next_state #(
    parameter int unsigned STAGES = 96,
    parameter int unsigned WIDE   = 3,
    parameter int unsigned NARROW = 6
) (
    input  logic [STAGES-1:0] cur,
    input  logic              mode_wide,
    input  logic              shift_right,
    input  logic [NARROW-1:0] a_din,
    input  logic [NARROW-1:0] b_din,
    output logic [STAGES-1:0] nxt
);
    import shreg_pkg::*;

    localparam int unsigned TAIL_W = STAGES - WIDE;
    localparam int unsigned TAIL_N = STAGES - NARROW;

    for (genvar j = 0; j < STAGES; j++) begin : g_stage
        logic rgt_w, rgt_n, lft_w, lft_n;

        // Right shift, wide layout: head stages take A-side inputs.
        if (j < WIDE) begin : g_rw_head
            assign rgt_w = a_din[j];
        end else begin : g_rw_body
            assign rgt_w = cur[j-WIDE];
        end

        // Right shift, narrow layout.
        if (j < NARROW) begin : g_rn_head
            assign rgt_n = a_din[j];
        end else begin : g_rn_body
            assign rgt_n = cur[j-NARROW];
        end

        // Left shift, wide layout: tail stages take B-side inputs.
        if (j >= TAIL_W) begin : g_lw_tail
            assign lft_w = b_din[j-TAIL_W];
        end else begin : g_lw_body
            assign lft_w = cur[j+WIDE];
        end

        // Left shift, narrow layout.
        if (j >= TAIL_N) begin : g_ln_tail
            assign lft_n = b_din[j-TAIL_N];
        end else begin : g_ln_body
            assign lft_n = cur[j+NARROW];
        end

        // Pick the candidate for the active layout and direction.
        always_comb begin
            if (shr_dir_e'(shift_right) == DIR_RIGHT) begin
                nxt[j] = mode_wide ? rgt_w : rgt_n;
            end else begin
                nxt[j] = mode_wide ? lft_w : lft_n;
            end
        end
    end

endmodule

// File: rtl/shreg_stage_bank.sv
// Module: the storage flops of all stages, cleared asynchronously.
// Assumes clr_n is glitch free; the clear wins over any clock edge.
module shreg_stage_bank #(
    parameter int unsigned STAGES = 96
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);

    // Hold stage contents; empty them whenever the clear is low.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/shreg_port_ctrl.sv
// Module: derives the per-port output enables and serial outputs.
// Assumes the A end of chain k is stage k and its B end is the last
// stage of that chain in the active layout.
module shreg_port_ctrl #(
    parameter int unsigned STAGES = 96,
    parameter int unsigned WIDE   = 3,
    parameter int unsigned NARROW = 6
) (
    input  logic [STAGES-1:0] cur,
    input  logic              mode_wide,
    input  logic              shift_right,
    output logic [NARROW-1:0] a_dout,
    output logic [NARROW-1:0] a_oe,
    output logic [NARROW-1:0] b_dout,
    output logic [NARROW-1:0] b_oe
);
    import shreg_pkg::*;

    localparam int unsigned TAIL_W = STAGES - WIDE;
    localparam int unsigned TAIL_N = STAGES - NARROW;

    for (genvar k = 0; k < NARROW; k++) begin : g_port
        logic active, b_val;

        // Ports beyond the wide chain count exist only in the narrow layout.
        if (k < WIDE) begin : g_shared
            assign active = 1'b1;
            assign b_val  = mode_wide ? cur[TAIL_W+k] : cur[TAIL_N+k];
        end else begin : g_narrow_only
            assign active = ~mode_wide;
            assign b_val  = ~mode_wide & cur[TAIL_N+k];
        end

        // Enable the side opposite the feeding side; gate data by enable.
        always_comb begin
            a_oe[k]   = active & (shr_dir_e'(shift_right) == DIR_LEFT);
            b_oe[k]   = active & (shr_dir_e'(shift_right) == DIR_RIGHT);
            a_dout[k] = a_oe[k] & cur[k];
            b_dout[k] = b_oe[k] & b_val;
        end
    end

endmodule

// File: rtl/interleaved_shreg.sv
// Module: top of the interleaved bidirectional shift register. It splits
// STAGES stages into WIDE or NARROW interleaved chains and shifts them
// together in the selected direction.
// Assumes inputs change away from the rising clock edge.
module interleaved_shreg #(
    parameter int unsigned STAGES = 96,
    parameter int unsigned WIDE   = 3,
    parameter int unsigned NARROW = 6
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift_right,
    input  logic              mode_wide,
    input  logic [NARROW-1:0] a_din,
    output logic [NARROW-1:0] a_dout,
    output logic [NARROW-1:0] a_oe,
    input  logic [NARROW-1:0] b_din,
    output logic [NARROW-1:0] b_dout,
    output logic [NARROW-1:0] b_oe,
    output logic [STAGES-1:0] stages
);

    logic [STAGES-1:0] cur_q;
    logic [STAGES-1:0] nxt_d;

    shreg_next_state #(.STAGES(STAGES), .WIDE(WIDE), .NARROW(NARROW)) i_next (
        .cur         (cur_q),
        .mode_wide   (mode_wide),
        .shift_right (shift_right),
        .a_din       (a_din),
        .b_din       (b_din),
        .nxt         (nxt_d)
    );

    shreg_stage_bank #(.STAGES(STAGES)) i_bank (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (nxt_d),
        .q     (cur_q)
    );

    shreg_port_ctrl #(.STAGES(STAGES), .WIDE(WIDE), .NARROW(NARROW)) i_ports (
        .cur         (cur_q),
        .mode_wide   (mode_wide),
        .shift_right (shift_right),
        .a_dout      (a_dout),
        .a_oe        (a_oe),
        .b_dout      (b_dout),
        .b_oe        (b_oe)
    );

    // Present the stage contents to the downstream latch.
    always_comb stages = cur_q;

endmodule

// File: rtl/shreg_checker.sv
// Module: temporal checks on the interleaved shift register, bound to its top.
// Assumes clear pulses span at least one rising edge.
module shreg_checker #(
    parameter int unsigned STAGES = 96,
    parameter int unsigned WIDE   = 3,
    parameter int unsigned NARROW = 6
) (
    input logic              clk,
    input logic              clr_n,
    input logic              shift_right,
    input logic              mode_wide,
    input logic [NARROW-1:0] a_din,
    input logic [NARROW-1:0] a_dout,
    input logic [NARROW-1:0] a_oe,
    input logic [NARROW-1:0] b_din,
    input logic [NARROW-1:0] b_dout,
    input logic [NARROW-1:0] b_oe,
    input logic [STAGES-1:0] stages
);

    p_clear_r1: assert property (@(posedge clk) !clr_n |-> stages == '0);

    p_right_wide_r2: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(shift_right) && $past(mode_wide))
        |-> stages == {$past(stages[STAGES-1-WIDE:0]), $past(a_din[WIDE-1:0])});

    p_right_narrow_r3: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(shift_right) && !$past(mode_wide))
        |-> stages == {$past(stages[STAGES-1-NARROW:0]), $past(a_din)});

    p_left_wide_r4: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && !$past(shift_right) && $past(mode_wide))
        |-> stages == {$past(b_din[WIDE-1:0]), $past(stages[STAGES-1:WIDE])});

    p_left_narrow_r5: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && !$past(shift_right) && !$past(mode_wide))
        |-> stages == {$past(b_din), $past(stages[STAGES-1:NARROW])});

    p_oe_exclusive_r6: assert property (@(posedge clk) (a_oe & b_oe) == '0);

    p_oe_unused_r6: assert property (@(posedge clk)
        mode_wide |-> (a_oe[NARROW-1:WIDE] == '0) && (b_oe[NARROW-1:WIDE] == '0));

    p_dout_quiet_r7: assert property (@(posedge clk)
        ((a_dout & ~a_oe) == '0) && ((b_dout & ~b_oe) == '0));

endmodule

bind interleaved_shreg shreg_checker #(.STAGES(STAGES), .WIDE(WIDE), .NARROW(NARROW)) i_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .shift_right (shift_right),
    .mode_wide   (mode_wide),
    .a_din       (a_din),
    .a_dout      (a_dout),
    .a_oe        (a_oe),
    .b_din       (b_din),
    .b_dout      (b_dout),
    .b_oe        (b_oe),
    .stages      (stages)
);

// File: tb/test_interleaved_shreg.sv
// Bench: walks a stimulus table against a chain-based reference model,
// then runs directed tests for clear, long fills and ignored inputs.
module test_interleaved_shreg;

    localparam int N = 96;
    localparam int P = 6;
    localparam int NVEC = 16;

    // Each vector: {mode_wide, shift_right, a_din[5:0], b_din[5:0]}.
    localparam logic [13:0] VEC [NVEC] = '{
        14'b11_101101_000000, 14'b11_010011_111111, 14'b11_111000_010101,
        14'b01_101010_110011, 14'b01_011101_001100, 14'b01_111111_000000,
        14'b00_000000_101101, 14'b00_111111_011110, 14'b10_110110_100111,
        14'b10_001001_011001, 14'b10_111111_111010, 14'b11_000111_000000,
        14'b01_100001_111111, 14'b00_010101_110000, 14'b10_000000_000101,
        14'b11_111111_111111
    };

    logic clk = 1'b0;
    logic clr_n = 1'b1;
    logic shift_right = 1'b1;
    logic mode_wide = 1'b1;
    logic [P-1:0] a_din = '0;
    logic [P-1:0] b_din = '0;
    logic [P-1:0] a_dout, a_oe, b_dout, b_oe;
    logic [N-1:0] stages;

    logic [N-1:0] model = '0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    interleaved_shreg i_interleaved_shreg (
        .clk(clk), .clr_n(clr_n), .shift_right(shift_right), .mode_wide(mode_wide),
        .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe),
        .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe), .stages(stages)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: per-chain positions, stage index = chain + position * chains.
    function automatic logic [N-1:0] model_next(input logic [N-1:0] m, input logic wide,
                                                input logic rgt, input logic [P-1:0] a,
                                                input logic [P-1:0] b);
        logic [N-1:0] r;
        int c, len;
        c = wide ? 3 : 6;
        len = N / c;
        r = m;
        for (int k = 0; k < c; k++) begin
            for (int p = 0; p < len; p++) begin
                if (rgt) r[k+p*c] = (p == 0) ? a[k] : m[k+(p-1)*c];
                else     r[k+p*c] = (p == len-1) ? b[k] : m[k+(p+1)*c];
            end
        end
        return r;
    endfunction

    // Check enables and serial outputs against the model state.
    task automatic chk_ports();
        logic [P-1:0] act_mask, e_aoe, e_boe, e_ad, e_bd;
        int c;
        c = mode_wide ? 3 : 6;
        act_mask = mode_wide ? 6'b000111 : 6'b111111;
        e_aoe = shift_right ? '0 : act_mask;
        e_boe = shift_right ? act_mask : '0;
        for (int k = 0; k < P; k++) begin
            e_ad[k] = e_aoe[k] & model[k];
            e_bd[k] = e_boe[k] & ((k < c) ? model[N-c+k] : 1'b0);
        end
        chk("R6 a_oe", N'(a_oe), N'(e_aoe));
        chk("R6 b_oe", N'(b_oe), N'(e_boe));
        chk("R7 a_dout", N'(a_dout), N'(e_ad));
        chk("R7 b_dout", N'(b_dout), N'(e_bd));
    endtask

    // One shift: drive at the falling edge, check ports, clock, check stages.
    task automatic step(input logic wide, input logic rgt, input logic [P-1:0] a,
                        input logic [P-1:0] b);
        mode_wide = wide; shift_right = rgt; a_din = a; b_din = b;
        #1 chk_ports();
        @(posedge clk);
        model = model_next(model, wide, rgt, a, b);
        @(negedge clk);
        if (wide && rgt)       chk("R2 right shift, three chains", stages, model);
        else if (!wide && rgt) chk("R3 right shift, six chains", stages, model);
        else if (wide)         chk("R4 left shift, three chains", stages, model);
        else                   chk("R5 left shift, six chains", stages, model);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] held;
        #2 clr_n = 1'b0;
        #1 chk("R1 reset state", stages, '0);
        @(negedge clk);
        clr_n = 1'b1;
        model = '0;
        chk_ports();

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][13], VEC[i][12], VEC[i][11:6], VEC[i][5:0]);
        end

        // Long right fill in three-chain mode so data reaches the B ports.
        for (int i = 0; i < 34; i++) step(1'b1, 1'b1, 6'(i * 5 + 3), 6'b111111);
        // Long left fill in six-chain mode so data reaches the A ports.
        for (int i = 0; i < 18; i++) step(1'b0, 1'b0, 6'b111111, 6'(i * 7 + 1));

        // R8: unused ports 3..5 in three-chain mode have no effect.
        step(1'b1, 1'b1, 6'b111000, 6'b111111);
        chk("R8 unused A ports ignored", N'(stages[2:0]), N'(3'b000));
        step(1'b1, 1'b0, 6'b111111, 6'b111000);
        chk("R8 unused B ports ignored", N'(stages[N-1:N-3]), N'(3'b000));

        // Mode switch keeps contents; then shift in six-chain mode.
        step(1'b0, 1'b1, 6'b101011, 6'b010101);
        step(1'b1, 1'b0, 6'b110110, 6'b001101);

        // R1: clear mid-cycle with no clock edge, then hold it across an edge.
        held = stages;
        chk("R1 content before clear is nonzero", N'(held != '0), N'(1));
        #2 clr_n = 1'b0;
        #1 chk("R1 async clear without edge", stages, '0);
        mode_wide = 1'b0; shift_right = 1'b1; a_din = 6'b111111;
        @(posedge clk);
        @(negedge clk);
        chk("R1 edge during clear ignored", stages, '0);
        clr_n = 1'b1;
        model = '0;
        step(1'b0, 1'b1, 6'b111111, 6'b000000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule